// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of the colour subcarrier that a video encoder feeds to its sine lookup before quadrature modulation. A 24-bit accumulator adds a programmable frequency word once every four 27 MHz sample enables, so one full accumulator wrap is one subcarrier cycle. The word equals 2^26 × fsc / 27 MHz; for example 0x87C1F1 selects the 525-line NTSC carrier and 0xA8262B the common 625-line PAL carrier. The top nine bits of the accumulator, plus a 9-bit offset that trims the carrier against the horizontal sync edge (nominally zero), form the phase word.

Two long-term corrections keep the carrier exact. In the 625-line standards an 8-bit adjustment is added to the accumulator once per eight-field sequence. In NTSC the accumulator is cleared at every line end unless a disable bit is set. For every PAL standard the block also provides a flag that flips at each line end and tells the modulator which of the two alternating burst and V-axis phases the coming line uses.

Top module: `sc_phase_gen`

## Requirements
- R1: While `rst_n` is low, `phase_out` and `pal_sw` are 0.
- R2: The 24-bit accumulator adds `freq_word` once for every four clock cycles in which `samp_en` is high, on the edge of the fourth one. Cycles with `samp_en` low do not advance it.
- R3: `phase_out` equals (accumulator bits 23..15 + `sch_off`) mod 512 and shows the accumulator and offset values in effect from the same clock edge.
- R4: With `std_sel` = 0 (NTSC) and `nco_rst_dis` = 0, a `line_end` cycle clears the accumulator and the enable count. This takes priority over a step or an adjustment in the same cycle.
- R5: With `nco_rst_dis` = 1, `line_end` leaves the accumulator unchanged.
- R6: With `std_sel` = 1 or 3 (625-line), `sc_adj` is added to the accumulator LSBs on the 8th, 16th, 24th … `field_stb` after reset. The field count wraps after eight.
- R7: With `std_sel` = 0 or 2 (525-line), `field_stb` never adds `sc_adj`.
- R8: With `std_sel` = 1, 2 or 3, `line_end` toggles `pal_sw` one clock later and does not clear the accumulator.
- R9: With `std_sel` = 0, `pal_sw` is 0 one clock later.
- R10: The accumulator wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | One pulse per 27 MHz sample |
| line_end | input | 1 | Single-cycle end-of-line strobe |
| field_stb | input | 1 | Single-cycle field start strobe |
| std_sel | input | 2 | 0 NTSC, 1 PAL-B/D/G/H/I, 2 PAL-M, 3 PAL-N |
| freq_word | input | 24 | Accumulator increment per step |
| sc_adj | input | 8 | Per-sequence correction (625-line) |
| sch_off | input | 9 | Phase offset to horizontal sync |
| nco_rst_dis | input | 1 | Disables NTSC per-line clear |
| phase_out | output | 9 | Subcarrier phase word |
| pal_sw | output | 1 | Per-line PAL phase alternation flag |

## Verification
Every result is due on the first rising edge after its stimulus: the phase register is loaded from the next accumulator value, so steps, adjustments, line clears and offset changes all show after a single edge, and so does the `pal_sw` toggle. The bench drives inputs on falling edges and samples on the falling edge that follows the edge in question. For an offset change it also samples 1 ns after driving, before any edge, to confirm that the old value is still held. Field and line strobes are driven with `samp_en` low, so a single unobserved step cannot hide an adjustment.

// File: rtl/sc_phase_pkg.sv
package sc_phase_pkg;
    typedef enum logic [1:0] {
        STD_NTSC   = 2'd0,
        STD_PAL_BG = 2'd1,
        STD_PAL_M  = 2'd2,
        STD_PAL_N  = 2'd3
    } vid_std_e;

    function automatic logic std_is_625(vid_std_e s);
        return (s == STD_PAL_BG) || (s == STD_PAL_N);
    endfunction

    function automatic logic std_is_ntsc(vid_std_e s);
        return s == STD_NTSC;
    endfunction
endpackage

// File: rtl/sc_step_div.sv
module sc_step_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic step
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (en)
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
    end

    assign step = en && !clr && (st_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sc_field_seq.sv
module sc_field_seq #(
    parameter int SEQ_SHORT = 4,
    parameter int SEQ_LONG  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fld_stb,
    input  logic long_seq,
    output logic seq_end
);
    localparam int W = $clog2(SEQ_LONG);
    localparam logic [W-1:0] LAST_S = W'(SEQ_SHORT - 1);
    localparam logic [W-1:0] LAST_L = W'(SEQ_LONG - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } fld_st_t;

    fld_st_t st_d, st_q;
    logic [W-1:0] last;

    always_comb begin
        last    = long_seq ? LAST_L : LAST_S;
        seq_end = fld_stb && (st_q.cnt >= last);
        st_d    = st_q;
        if (fld_stb)
            st_d.cnt = (st_q.cnt >= last) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sc_line_ctl.sv
module sc_line_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic line_end,
    input  logic is_ntsc,
    input  logic rst_dis,
    output logic nco_clr,
    output logic pal_sw
);
    typedef struct packed {
        logic sw;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        nco_clr = line_end && is_ntsc && !rst_dis;
        st_d    = st_q;
        if (is_ntsc)
            st_d.sw = 1'b0;
        else if (line_end)
            st_d.sw = !st_q.sw;
    end

    assign pal_sw = st_q.sw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sc_phase_gen.sv
module sc_phase_gen
    import sc_phase_pkg::*;
#(
    parameter int ACC_W     = 24,
    parameter int ADJ_W     = 8,
    parameter int OFF_W     = 9,
    parameter int STEP_DIV  = 4,
    parameter int SEQ_525   = 4,
    parameter int SEQ_625   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             line_end,
    input  logic             field_stb,
    input  logic [1:0]       std_sel,
    input  logic [ACC_W-1:0] freq_word,
    input  logic [ADJ_W-1:0] sc_adj,
    input  logic [OFF_W-1:0] sch_off,
    input  logic             nco_rst_dis,
    output logic [OFF_W-1:0] phase_out,
    output logic             pal_sw
);
    localparam int PAD_W = ACC_W - ADJ_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [OFF_W-1:0] phase;
    } gen_st_t;

    gen_st_t  st_d, st_q;
    vid_std_e std;
    logic     step, seq_end, nco_clr, add_adj;

    assign std = vid_std_e'(std_sel);

    sc_step_div #(.DIV(STEP_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (samp_en),
        .clr  (nco_clr),
        .step (step)
    );

    sc_field_seq #(.SEQ_SHORT(SEQ_525), .SEQ_LONG(SEQ_625)) u_fld (
        .clk     (clk),
        .rst_n   (rst_n),
        .fld_stb (field_stb),
        .long_seq(std_is_625(std)),
        .seq_end (seq_end)
    );

    sc_line_ctl u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_end(line_end),
        .is_ntsc (std_is_ntsc(std)),
        .rst_dis (nco_rst_dis),
        .nco_clr (nco_clr),
        .pal_sw  (pal_sw)
    );

    assign add_adj = seq_end && std_is_625(std);

    always_comb begin
        st_d = st_q;
        if (nco_clr) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = st_q.acc
                     + (step    ? freq_word : '0)
                     + (add_adj ? {{PAD_W{1'b0}}, sc_adj} : '0);
        end
        st_d.phase = st_d.acc[ACC_W-1 -: OFF_W] + sch_off;
    end

    assign phase_out = st_q.phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sc_phase_gen_chk.sv
module sc_phase_gen_chk #(
    parameter int OFF_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_en,
    input logic             line_end,
    input logic             field_stb,
    input logic [1:0]       std_sel,
    input logic [OFF_W-1:0] sch_off,
    input logic             nco_rst_dis,
    input logic [OFF_W-1:0] phase_out,
    input logic             pal_sw
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    always @(posedge clk)
        if (!rst_n) assert (phase_out == '0 && !pal_sw); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !samp_en && !line_end && !field_stb && sch_off == $past(sch_off))
        |=> $stable(phase_out)); // R2

    AST_NTSC_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && std_sel == 2'd0 && !nco_rst_dis)
        |=> phase_out == $past(sch_off)); // R4

    AST_CLEAR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && line_end && nco_rst_dis && !samp_en && !field_stb && sch_off == $past(sch_off))
        |=> $stable(phase_out)); // R5

    AST_PAL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && std_sel != 2'd0) |=> pal_sw != $past(pal_sw)); // R8

    AST_NTSC_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (std_sel == 2'd0) |=> !pal_sw); // R9
endmodule

bind sc_phase_gen sc_phase_gen_chk #(.OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .line_end   (line_end),
    .field_stb  (field_stb),
    .std_sel    (std_sel),
    .sch_off    (sch_off),
    .nco_rst_dis(nco_rst_dis),
    .phase_out  (phase_out),
    .pal_sw     (pal_sw)
);

// File: tb/tb_sc_phase_gen.sv
module tb_sc_phase_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_en = 1'b0, line_end = 1'b0, field_stb = 1'b0;
    logic [1:0]  std_sel = 2'd0;
    logic [23:0] freq_word = 24'd0;
    logic [7:0]  sc_adj = 8'd0;
    logic [8:0]  sch_off = 9'd0;
    logic        nco_rst_dis = 1'b0;
    logic [8:0]  phase_out;
    logic        pal_sw;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sc_phase_gen dut (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line_end(line_end),
        .field_stb(field_stb), .std_sel(std_sel), .freq_word(freq_word),
        .sc_adj(sc_adj), .sch_off(sch_off), .nco_rst_dis(nco_rst_dis),
        .phase_out(phase_out), .pal_sw(pal_sw)
    );

    function automatic logic [8:0] exp_phase(logic [23:0] f, logic [8:0] off, int nen);
        longint unsigned a;
        a = (longint'(nen / 4) * longint'(f)) % 64'd16777216;
        return 9'((a >> 15) + off);
    endfunction

    typedef struct packed {
        logic [1:0]  std;
        logic [23:0] freq;
        logic [8:0]  off;
        logic [15:0] nen;
        logic [8:0]  exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 24'h87C1F1, 9'h000, 16'd32,  exp_phase(24'h87C1F1, 9'h000, 32)},
        '{2'd1, 24'hA8262B, 9'h000, 16'd40,  exp_phase(24'hA8262B, 9'h000, 40)},
        '{2'd2, 24'h879BC0, 9'h010, 16'd17,  exp_phase(24'h879BC0, 9'h010, 17)},
        '{2'd3, 24'h87DA51, 9'h1FF, 16'd100, exp_phase(24'h87DA51, 9'h1FF, 100)},
        '{2'd1, 24'hFFFFFF, 9'h001, 16'd8,   9'h000},
        '{2'd0, 24'h87C1F1, 9'h123, 16'd3,   9'h123}
    };

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 phase in reset", phase_out, 9'd0);
        check("R1 pal_sw in reset", {8'd0, pal_sw}, 9'd0);
        rst_n = 1'b1;
    endtask

    task automatic run_en(int n);
        @(negedge clk);
        samp_en = 1'b1;
        repeat (n) @(negedge clk);
        samp_en = 1'b0;
    endtask

    task automatic pulse_line();
        @(negedge clk);
        line_end = 1'b1;
        @(negedge clk);
        line_end = 1'b0;
    endtask

    task automatic pulse_fields(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            field_stb = 1'b1;
            @(negedge clk);
            field_stb = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] p;
        // R2 R3 R10: vector walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            std_sel   = VECS[v].std;
            freq_word = VECS[v].freq;
            sch_off   = VECS[v].off;
            run_en(int'(VECS[v].nen));
            check($sformatf("R2/R3/R10 vector %0d", v), phase_out, VECS[v].exp);
        end

        // R3: offset latency
        do_reset();
        std_sel = 2'd1; freq_word = 24'h123456; sch_off = 9'd0;
        run_en(4);
        p = exp_phase(24'h123456, 9'd0, 4);
        check("R3 phase after one step", phase_out, p);
        @(negedge clk);
        sch_off = 9'd77;
        #1 check("R3 offset not yet applied", phase_out, p);
        @(negedge clk);
        check("R3 offset applied", phase_out, exp_phase(24'h123456, 9'd77, 4));

        // R4: NTSC line clear, divider cleared too
        do_reset();
        std_sel = 2'd0; freq_word = 24'h87C1F1; sch_off = 9'd5; nco_rst_dis = 1'b0;
        run_en(6);
        check("R4 before clear", phase_out, exp_phase(24'h87C1F1, 9'd5, 6));
        pulse_line();
        check("R4 after clear", phase_out, 9'd5);
        run_en(2);
        check("R4 divider cleared", phase_out, 9'd5);
        check("R9 pal_sw in NTSC", {8'd0, pal_sw}, 9'd0);

        // R5: clear disabled
        do_reset();
        nco_rst_dis = 1'b1;
        run_en(4);
        p = exp_phase(24'h87C1F1, 9'd5, 4);
        pulse_line();
        check("R5 no clear when disabled", phase_out, p);
        nco_rst_dis = 1'b0;

        // R8: PAL alternation, no clear
        do_reset();
        std_sel = 2'd1; freq_word = 24'h87DA51; sch_off = 9'd0;
        run_en(8);
        p = exp_phase(24'h87DA51, 9'd0, 8);
        pulse_line();
        check("R8 pal_sw toggled", {8'd0, pal_sw}, 9'd1);
        check("R8 no clear in PAL", phase_out, p);
        pulse_line();
        check("R8 pal_sw toggled back", {8'd0, pal_sw}, 9'd0);
        std_sel = 2'd2;
        pulse_line();
        check("R8 pal_sw PAL-M toggle", {8'd0, pal_sw}, 9'd1);
        std_sel = 2'd0;
        @(negedge clk);
        check("R9 pal_sw cleared on NTSC", {8'd0, pal_sw}, 9'd0);

        // R6: adjustment on 8th field
        do_reset();
        std_sel = 2'd1; freq_word = 24'h007F80; sc_adj = 8'h80; sch_off = 9'd0;
        run_en(4);
        check("R6 base phase", phase_out, 9'd0);
        pulse_fields(7);
        check("R6 no adjust before 8th field", phase_out, 9'd0);
        pulse_fields(1);
        check("R6 adjust on 8th field", phase_out, 9'd1);

        // R6: wrap after eight
        do_reset();
        std_sel = 2'd3; freq_word = 24'h007F00;
        run_en(4);
        pulse_fields(15);
        check("R6 one adjust after 15 fields", phase_out, 9'd0);
        pulse_fields(1);
        check("R6 second adjust on 16th field", phase_out, 9'd1);

        // R7: no adjustment in 525-line modes
        do_reset();
        std_sel = 2'd0; freq_word = 24'h007F80; nco_rst_dis = 1'b0;
        run_en(4);
        pulse_fields(8);
        check("R7 NTSC ignores adjust", phase_out, 9'd0);
        do_reset();
        std_sel = 2'd2;
        run_en(4);
        pulse_fields(8);
        check("R7 PAL-M ignores adjust", phase_out, 9'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule